// File: doc/BRIEF.md
# LIN Transceiver Power-Mode Controller

This block is the digital sequencer of a LIN bus transceiver. It moves the transceiver through five power and operating modes. For each mode it drives the enables of the voltage regulator, the bus receiver, the bus transmitter and the bus pull-up, and it drives an active-low reset output for the attached microcontroller. The analog parts supply their results as digital flags:

- supply above the turn-on level;
- supply below the turn-off level;
- regulator output OK;
- bus below the wake threshold.

Fault flags for over-temperature, a bus short to supply and a stuck-dominant line also arrive as inputs. The chip-select/local-wake pin and the transmit-data pin arrive already synchronized to `clk`.

Two timers are built in, and both count `clk` cycles. The first qualifies the drop from transmitter-off to power-down, so that a short low glitch on both pins does not shut the regulator down. The second filters bus activity while in power-down. A wake from the bus needs a low period of at least the programmed length, followed by a release of the bus.

Top module: `lin_pwr_ctrl`

## Requirements
- R1: `mode_o` encodes the modes as 0 power-on reset, 1 ready, 2 operation, 3 transmitter-off and 4 power-down. While `rst_n` is low the mode is power-on reset.
- R2: In every mode, `sup_low_i` high at a clock edge puts the controller in power-on reset after that edge. This takes priority over every other transition.
- R3: Power-on reset is left for ready only at an edge where `sup_on_i` is high and `sup_low_i` is low. Otherwise the controller stays in power-on reset.
- R4: In power-on reset and power-down, `reg_en_o`, `rx_en_o`, `tx_en_o` and `pullup_en_o` are all low. In ready and transmitter-off, `reg_en_o` and `rx_en_o` are high and `tx_en_o` is low. `rst_o` is low only in power-on reset.
- R5: Ready is held until `reg_ok_i` and `cs_i` are both high. With `txd_i` high and no fault, the next mode is operation. With `txd_i` low, the next mode is transmitter-off.
- R6: Operation drops to transmitter-off after a falling edge of `cs_i`. It also drops to transmitter-off when any fault is present. The faults are `flt_therm_i`, `flt_short_i`, `flt_dom_i`, or `reg_ok_i` low.
- R7: Transmitter-off goes to operation when `cs_i`, `txd_i` and `reg_ok_i` are high and no fault flag is set. While a fault is present the controller stays in transmitter-off.
- R8: Transmitter-off goes to power-down only after `cs_i` and `txd_i` have both been low at DEGLITCH_CYC consecutive edges. A high on either pin restarts the count.
- R9: `tx_en_o` is high only in operation with no fault present, and it drops in the same cycle as a fault appears. `pullup_en_o` is high only in operation.
- R10: Power-down goes to ready at the edge after `cs_i` is high.
- R11: Power-down goes to ready after `bus_low_i` has been high at WAKE_CYC or more consecutive edges in power-down and then goes low. A shorter low period on the bus causes no wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_on_i | input | 1 | Supply above turn-on level |
| sup_low_i | input | 1 | Supply below turn-off level |
| reg_ok_i | input | 1 | Regulator output within range |
| bus_low_i | input | 1 | Bus below wake threshold |
| cs_i | input | 1 | Chip-select / local wake, synchronized |
| txd_i | input | 1 | Transmit data, synchronized |
| flt_therm_i | input | 1 | Thermal shutdown flag |
| flt_short_i | input | 1 | Bus shorted to supply flag |
| flt_dom_i | input | 1 | Stuck-dominant flag |
| reg_en_o | output | 1 | Regulator enable |
| rx_en_o | output | 1 | Receiver enable |
| tx_en_o | output | 1 | Transmitter enable |
| pullup_en_o | output | 1 | Bus pull-up enable |
| rst_o | output | 1 | Reset output, active low |
| mode_o | output | 3 | Current mode code |

## Verification
The bench builds the controller with DEGLITCH_CYC = 6 and WAKE_CYC = 10, instead of the defaults of thousands of cycles. At these values the bench can check the exact edge where each timer expires, one cycle after the last edge where it has not. It can also check that an interrupted deglitch restarts its count, and that a bus low one cycle shorter than the filter causes no wake. All of this fits in a few hundred cycles.

// File: rtl/lin_pwr_ctrl.sv
module lin_pwr_ctrl #(
  parameter int DEGLITCH_CYC = 2000,
  parameter int WAKE_CYC     = 8000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sup_on_i,
  input  logic       sup_low_i,
  input  logic       reg_ok_i,
  input  logic       bus_low_i,
  input  logic       cs_i,
  input  logic       txd_i,
  input  logic       flt_therm_i,
  input  logic       flt_short_i,
  input  logic       flt_dom_i,
  output logic       reg_en_o,
  output logic       rx_en_o,
  output logic       tx_en_o,
  output logic       pullup_en_o,
  output logic       rst_o,
  output logic [2:0] mode_o
);
  localparam logic [2:0] M_POR = 3'd0, M_RDY = 3'd1, M_OPR = 3'd2,
                         M_TXO = 3'd3, M_PDN = 3'd4;
  localparam int DGW = $clog2(DEGLITCH_CYC + 1);
  localparam int WKW = $clog2(WAKE_CYC + 1);

  logic [2:0]     mode, mode_nx;
  logic           cs_q;
  logic [DGW-1:0] dg_cnt;
  logic [WKW-1:0] wk_cnt;

  wire fault  = flt_therm_i | flt_short_i | flt_dom_i | ~reg_ok_i;
  wire dg_arm = (mode == M_TXO) & ~cs_i & ~txd_i;
  wire dg_go  = dg_arm & (dg_cnt == DGW'(DEGLITCH_CYC - 1));
  wire wk_go  = (mode == M_PDN) & ~bus_low_i & (wk_cnt == WKW'(WAKE_CYC));

  always_comb begin
    mode_nx = mode;
    if (sup_low_i) mode_nx = M_POR;
    else begin
      case (mode)
        M_POR: if (sup_on_i) mode_nx = M_RDY;
        M_RDY: if (cs_i && reg_ok_i) begin
                 if (!txd_i) mode_nx = M_TXO;
                 else if (!fault) mode_nx = M_OPR;
               end
        M_OPR: if (fault || (cs_q && !cs_i)) mode_nx = M_TXO;
        M_TXO: if (cs_i && txd_i && !fault) mode_nx = M_OPR;
               else if (dg_go) mode_nx = M_PDN;
        M_PDN: if (cs_i || wk_go) mode_nx = M_RDY;
        default: mode_nx = M_POR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= M_POR;
      cs_q   <= 1'b0;
      dg_cnt <= '0;
      wk_cnt <= '0;
    end else begin
      mode <= mode_nx;
      cs_q <= cs_i;
      if (dg_arm && !dg_go) dg_cnt <= dg_cnt + 1'b1;
      else                  dg_cnt <= '0;
      if (mode != M_PDN || !bus_low_i)      wk_cnt <= '0;
      else if (wk_cnt != WKW'(WAKE_CYC))    wk_cnt <= wk_cnt + 1'b1;
    end
  end

  assign mode_o      = mode;
  assign reg_en_o    = (mode == M_RDY) | (mode == M_OPR) | (mode == M_TXO);
  assign rx_en_o     = reg_en_o;
  assign pullup_en_o = (mode == M_OPR);
  assign tx_en_o     = pullup_en_o & ~fault;
  assign rst_o       = (mode != M_POR);

  assert_supdrop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sup_low_i |=> mode_o == M_POR);
  assert_porexit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == M_RDY && $past(mode_o) == M_POR) |-> $past(sup_on_i));
  assert_operentry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == M_OPR && $past(mode_o) != M_OPR) |-> ($past(cs_i) && $past(txd_i) && $past(reg_ok_i)));
  assert_pdentry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == M_PDN && $past(mode_o) != M_PDN) |-> ($past(mode_o) == M_TXO && !$past(cs_i) && !$past(txd_i)));
  assert_txen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en_o |-> (pullup_en_o && reg_ok_i && !flt_therm_i && !flt_short_i && !flt_dom_i));
endmodule

// File: tb/test_lin_pwr_ctrl.sv
module test_lin_pwr_ctrl;
  localparam int DG = 6;
  localparam int WK = 10;

  logic clk = 0, rst_n = 0;
  logic sup_on = 0, sup_low = 1, reg_ok = 0, bus_low = 0, cs = 0, txd = 0;
  logic f_th = 0, f_sh = 0, f_dm = 0;
  logic reg_en, rx_en, tx_en, pu_en, rst_out;
  logic [2:0] mode;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lin_pwr_ctrl #(.DEGLITCH_CYC(DG), .WAKE_CYC(WK)) i_lin_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .sup_on_i(sup_on), .sup_low_i(sup_low),
    .reg_ok_i(reg_ok), .bus_low_i(bus_low), .cs_i(cs), .txd_i(txd),
    .flt_therm_i(f_th), .flt_short_i(f_sh), .flt_dom_i(f_dm),
    .reg_en_o(reg_en), .rx_en_o(rx_en), .tx_en_o(tx_en),
    .pullup_en_o(pu_en), .rst_o(rst_out), .mode_o(mode));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // outputs packed as {reg,rx,tx,pu,rst}
  function automatic int outs();
    return {reg_en, rx_en, tx_en, pu_en, rst_out};
  endfunction

  task automatic t_reset;
    step(2);
    chk("R1 reset mode", mode, 0);
    chk("R4 POR outputs", outs(), 5'b00000);
  endtask

  task automatic t_por;
    rst_n = 1; step(3);
    chk("R3 stay POR while supply low", mode, 0);
    sup_low = 0; step(2);
    chk("R3 stay POR without turn-on", mode, 0);
    sup_on = 1; step(1);
    chk("R3 POR to ready", mode, 1);
    chk("R4 ready outputs", outs(), 5'b11001);
  endtask

  task automatic t_ready;
    cs = 1; txd = 1; step(2);
    chk("R5 ready waits for regulator", mode, 1);
    reg_ok = 1; step(1);
    chk("R5 ready to operation", mode, 2);
    chk("R9 operation outputs", outs(), 5'b11111);
  endtask

  task automatic t_fault;
    f_th = 1; #1;
    chk("R9 tx off at fault", tx_en, 0);
    step(1);
    chk("R6 fault to txoff", mode, 3);
    f_th = 0; f_sh = 1; step(2);
    chk("R7 fault blocks operation", mode, 3);
    chk("R4 txoff outputs", outs(), 5'b11001);
    f_sh = 0; step(1);
    chk("R7 txoff to operation", mode, 2);
    reg_ok = 0; step(1);
    chk("R6 regulator loss to txoff", mode, 3);
    reg_ok = 1; step(1);
    chk("R7 back to operation", mode, 2);
  endtask

  task automatic t_csfall;
    cs = 0; step(1);
    chk("R6 cs falling to txoff", mode, 3);
    step(DG + 2);
    chk("R8 txd high keeps txoff", mode, 3);
  endtask

  task automatic t_deglitch;
    txd = 0; step(DG - 1);
    chk("R8 not yet power-down", mode, 3);
    txd = 1; step(1);
    txd = 0; step(DG - 1);
    chk("R8 restarted count", mode, 3);
    step(1);
    chk("R8 power-down entered", mode, 4);
    chk("R4 power-down outputs", outs(), 5'b00001);
  endtask

  task automatic t_cswake;
    cs = 1; step(1);
    chk("R10 cs wakes to ready", mode, 1);
    txd = 0; step(1);
    chk("R5 ready to txoff with txd low", mode, 3);
    cs = 0; step(DG);
    chk("R8 back to power-down", mode, 4);
  endtask

  task automatic t_buswake;
    bus_low = 1; step(WK - 1);
    bus_low = 0; step(2);
    chk("R11 short low ignored", mode, 4);
    bus_low = 1; step(WK + 3);
    chk("R11 still asleep while low", mode, 4);
    bus_low = 0; step(1);
    chk("R11 bus wake to ready", mode, 1);
  endtask

  task automatic t_supdrop;
    cs = 1; txd = 1; step(1);
    chk("R5 to operation", mode, 2);
    sup_low = 1; step(1);
    chk("R2 supply drop to POR", mode, 0);
    chk("R4 POR reset low", rst_out, 0);
  endtask

  initial begin
    t_reset;
    t_por;
    t_ready;
    t_fault;
    t_csfall;
    t_deglitch;
    t_cswake;
    t_buswake;
    t_supdrop;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule